// File: doc/BRIEF.md
# Double-Buffered PWM Channel

This block produces one pulse-width-modulated output from a counter that advances on ticks of a selectable clock prescaler. Software writes a period value and a width value into two user registers over a simple single-cycle register bus. The counter compares against working copies of those values. The working copies are reloaded from the user registers only when a new period begins. Software can therefore prepare the next period's values at any time without disturbing the period in progress.

A sticky status flag reports that a new period has started and that the user registers are free for new values. It sets when the channel is enabled and at the end of every period. Software clears it by reading it as one and then writing zero to it. While the flag is set and the programmed interrupt level is nonzero, the block raises an interrupt request and presents that level.

Top module: `pwm_dbl_chan`

## Requirements
- R1: After reset every register reads zero, `pwm_out` is 0, `irq_req` is 0 and `irq_lvl` is 0.
- R2: A control write with the enable bit (bit 7) set while the channel is off copies the user period and width into the working registers, restarts the counter at 0 and sets the flag (bit 15). All of this is visible after that clock edge.
- R3: The 3-bit clock select (bits 2:0) value s makes each count value last 2^s clock cycles, from 1 up to 128.
- R4: The counter runs from 0 up to the working period P and then wraps, so one period lasts (P+1)·2^s cycles. The raw output is active while the count is below the working width W, so W = 0 never asserts it and W > P always asserts it.
- R5: The polarity bit (bit 8) inverts `pwm_out`. While the channel is disabled, `pwm_out` equals the polarity bit.
- R6: Writes to the period register (address 1) or the width register (address 2) take effect only from the next period start.
- R7: The flag sets at every period end and stays set through later period ends until software clears it.
- R8: The flag clears only when a control write with bit 15 at zero follows a control read that returned the flag as one. A zero write without such a read, or a write of one, leaves it set.
- R9: A control write with bit 7 at zero disables the channel: the flag is held clear and the output goes to its inactive level.
- R10: `irq_req` is 1 exactly while the flag is set and the level field (bits 14:12) is nonzero. `irq_lvl` then shows that field and is 0 otherwise.
- R11: Control bit 10 reads back the current `pwm_out` level. Writing the load bit (bit 9) together with bit 7 while enabled restarts the period at once with fresh working copies. The load bit always reads 0.
- R12: The control register at address 0 reads back as flag 15, level 14:12, arbitration bit 11, pin 10, load 9, polarity 8, enable 7 and clock select 2:0. The user period and width read back at addresses 1 and 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_rd | input | 1 | Read strobe, arms the flag-clear handshake |
| bus_addr | input | 2 | Register address: 0 control, 1 period, 2 width |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pwm_out | output | 1 | PWM output after polarity |
| irq_req | output | 1 | Interrupt request |
| irq_lvl | output | 3 | Requested interrupt level, 0 when idle |

## Verification
A register write lands at the next rising edge, so the bench reads its effect at the following falling edge. This covers the flag set by an enable, the read-back fields, a flag clear and the request outputs. The count at that first falling edge after enable is 0, and every later count value lasts 2^s cycles. The bench therefore samples `pwm_out` at every falling edge for exactly two whole periods and compares the active-cycle total and the index of the first inactive sample with values computed from P, W and s. The double-buffer and load checks drive the bus inside the sampling loop at a known sample index, which fixes the edge at which each change takes effect.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
    localparam int BUS_W       = 16;
    localparam int SEL_W       = 3;
    localparam int LVL_W       = 3;
    localparam int CTL_FLAG    = 15;
    localparam int CTL_LVL_LO  = 12;
    localparam int CTL_ARB     = 11;
    localparam int CTL_PIN     = 10;
    localparam int CTL_LOAD    = 9;
    localparam int CTL_POL     = 8;
    localparam int CTL_EN      = 7;

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_PER  = 2'd1,
        RA_WID  = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale
    import pwm_chan_pkg::*;
#(
    parameter int PSEL_W = SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              restart,
    input  logic [PSEL_W-1:0] sel,
    output logic              tick
);
    localparam int PRE_W = (1 << PSEL_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t s_q, s_d;
    logic [PRE_W-1:0] lim;

    always_comb begin
        lim  = PRE_W'((1 << sel) - 1);
        tick = en && (s_q.pre >= lim);
        s_d  = s_q;
        if (!en || restart) begin
            s_d.pre = '0;
        end else if (tick) begin
            s_d.pre = '0;
        end else begin
            s_d.pre = s_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3: a tick always restarts the prescale count
    p_tick_restarts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (s_q.pre == '0));
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             start,
    input  logic             tick,
    input  logic             pol,
    input  logic [CNT_W-1:0] per_usr,
    input  logic [CNT_W-1:0] wid_usr,
    output logic             period_end,
    output logic             pwm_out
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per_w;
        logic [CNT_W-1:0] wid_w;
    } core_state_t;

    core_state_t s_q, s_d;

    always_comb begin
        period_end = tick && !start && (s_q.cnt == s_q.per_w);
        s_d = s_q;
        if (start) begin
            s_d.cnt   = '0;
            s_d.per_w = per_usr;
            s_d.wid_w = wid_usr;
        end else if (!en) begin
            s_d.cnt = '0;
        end else if (period_end) begin
            s_d.cnt   = '0;
            s_d.per_w = per_usr;
            s_d.wid_w = wid_usr;
        end else if (tick) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        pwm_out = (en && (s_q.cnt < s_q.wid_w)) ^ pol;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4: the count never passes the working period while running
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (s_q.cnt <= s_q.per_w));
    // R6: working copies change only at a period start
    p_work_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !period_end) |=> ($stable(s_q.per_w) && $stable(s_q.wid_w)));
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic             period_end,
    input  logic             pin,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             en,
    output logic             pol,
    output logic [SEL_W-1:0] clk_sel,
    output logic             start,
    output logic             flag,
    output logic [LVL_W-1:0] lvl,
    output logic [CNT_W-1:0] per_usr,
    output logic [CNT_W-1:0] wid_usr
);
    typedef struct packed {
        logic             flag;
        logic             armed;
        logic [LVL_W-1:0] lvl;
        logic             arb;
        logic             pol;
        logic             en;
        logic [SEL_W-1:0] csel;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] wid;
    } reg_state_t;

    reg_state_t s_q, s_d;
    logic ctrl_wr, ctrl_rd;
    logic [BUS_W-1:0] ctrl_word;

    always_comb begin
        ctrl_wr = bus_sel && bus_wr && (bus_addr == RA_CTRL);
        ctrl_rd = bus_sel && bus_rd && (bus_addr == RA_CTRL);
        start   = ctrl_wr && bus_wdata[CTL_EN] && (!s_q.en || bus_wdata[CTL_LOAD]);

        s_d = s_q;
        if (ctrl_wr) begin
            s_d.lvl  = bus_wdata[CTL_LVL_LO +: LVL_W];
            s_d.arb  = bus_wdata[CTL_ARB];
            s_d.pol  = bus_wdata[CTL_POL];
            s_d.en   = bus_wdata[CTL_EN];
            s_d.csel = bus_wdata[SEL_W-1:0];
        end
        if (bus_sel && bus_wr && (bus_addr == RA_PER)) s_d.per = bus_wdata[CNT_W-1:0];
        if (bus_sel && bus_wr && (bus_addr == RA_WID)) s_d.wid = bus_wdata[CNT_W-1:0];

        if (ctrl_rd && s_q.flag) s_d.armed = 1'b1;
        if (ctrl_wr) begin
            if (!bus_wdata[CTL_FLAG] && s_q.armed) s_d.flag = 1'b0;
            s_d.armed = 1'b0;
        end
        if (start || period_end) s_d.flag = 1'b1;
        if (!s_d.en) begin
            s_d.flag  = 1'b0;
            s_d.armed = 1'b0;
        end

        ctrl_word                         = '0;
        ctrl_word[CTL_FLAG]               = s_q.flag;
        ctrl_word[CTL_LVL_LO +: LVL_W]    = s_q.lvl;
        ctrl_word[CTL_ARB]                = s_q.arb;
        ctrl_word[CTL_PIN]                = pin;
        ctrl_word[CTL_POL]                = s_q.pol;
        ctrl_word[CTL_EN]                 = s_q.en;
        ctrl_word[SEL_W-1:0]              = s_q.csel;
        case (bus_addr)
            RA_CTRL: bus_rdata = ctrl_word;
            RA_PER:  bus_rdata = BUS_W'(s_q.per);
            RA_WID:  bus_rdata = BUS_W'(s_q.wid);
            default: bus_rdata = '0;
        endcase

        en      = s_q.en;
        pol     = s_q.pol;
        clk_sel = s_q.csel;
        flag    = s_q.flag;
        lvl     = s_q.lvl;
        per_usr = s_q.per;
        wid_usr = s_q.wid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2: an enabling write leaves the flag and enable set
    p_start_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (s_q.flag && s_q.en));
    // R7: without a control write the flag cannot fall
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flag && !ctrl_wr) |=> s_q.flag);
    // R8: writing one to the flag while staying enabled keeps it
    p_write_one_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flag && ctrl_wr && bus_wdata[CTL_FLAG] && bus_wdata[CTL_EN]) |=> s_q.flag);
    // R9: a disabled channel never shows the flag
    p_off_no_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.en |-> !s_q.flag);
endmodule

// File: rtl/pwm_dbl_chan.sv
module pwm_dbl_chan
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [15:0]      bus_wdata,
    output logic [15:0]      bus_rdata,
    output logic             pwm_out,
    output logic             irq_req,
    output logic [2:0]       irq_lvl
);
    logic             en, pol, start, flag, tick, period_end;
    logic [SEL_W-1:0] clk_sel;
    logic [LVL_W-1:0] lvl;
    logic [CNT_W-1:0] per_usr, wid_usr;

    pwm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .period_end(period_end), .pin(pwm_out),
        .bus_rdata(bus_rdata), .en(en), .pol(pol), .clk_sel(clk_sel),
        .start(start), .flag(flag), .lvl(lvl),
        .per_usr(per_usr), .wid_usr(wid_usr)
    );

    pwm_prescale #(.PSEL_W(SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(en), .restart(start),
        .sel(clk_sel), .tick(tick)
    );

    pwm_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .en(en), .start(start), .tick(tick),
        .pol(pol), .per_usr(per_usr), .wid_usr(wid_usr),
        .period_end(period_end), .pwm_out(pwm_out)
    );

    always_comb begin
        irq_req = flag && (lvl != '0);
        irq_lvl = irq_req ? lvl : '0;
    end

    // R10: a request always comes with the set flag and its programmed level
    p_irq_from_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (flag && (irq_lvl == lvl)));
endmodule

// File: tb/tb_pwm_dbl_chan.sv
`timescale 1ns/1ps
module tb_pwm_dbl_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        pwm_out, irq_req;
    logic [2:0]  irq_lvl;
    int          checks = 0, fails = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    pwm_dbl_chan dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pwm_out(pwm_out), .irq_req(irq_req),
        .irq_lvl(irq_lvl)
    );

    // vector: sel[2:0], period[15:0], width[15:0], polarity
    localparam logic [35:0] VEC [6] = '{
        {3'd0, 16'd3, 16'd1, 1'b0},
        {3'd1, 16'd4, 16'd2, 1'b0},
        {3'd2, 16'd2, 16'd3, 1'b0},
        {3'd0, 16'd5, 16'd0, 1'b0},
        {3'd3, 16'd3, 16'd1, 1'b1},
        {3'd7, 16'd1, 16'd1, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0; bus_addr = 2'd0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctrl", bus_rdata, 0);
        bus_addr = 2'd1; #1 chk("R1 period", bus_rdata, 0);
        bus_addr = 2'd2; #1 chk("R1 width", bus_rdata, 0);
        bus_addr = 2'd0;
        chk("R1 pwm_out", pwm_out, 0);
        chk("R1 irq_req", irq_req, 0);
        chk("R1 irq_lvl", irq_lvl, 0);

        // table walk: R2 R3 R4 R5
        for (int v = 0; v < 6; v++) begin
            logic [2:0]  s;
            logic [15:0] p, w;
            logic        pl;
            int          len, hi, hi_exp, first_low, fl_exp;
            bit          seen;
            {s, p, w, pl} = VEC[v];
            len = 2 * (p + 1) * (1 << s);
            hi_exp = 2 * ((w > p) ? (p + 1) : w) * (1 << s);
            if (pl) hi_exp = len - hi_exp;
            fl_exp = (w > p) ? len : (w << s);
            wr(2'd0, 16'h0000);
            wr(2'd1, p);
            wr(2'd2, w);
            wr(2'd0, 16'h0080 | (16'(pl) << 8) | 16'(s));
            chk("R2 flag on enable", bus_rdata[15], 1);
            hi = 0; first_low = len; seen = 1'b0;
            for (int i = 0; i < len; i++) begin
                if (pwm_out) hi++;
                if (!seen && ((pwm_out ^ pl) == 1'b0)) begin
                    first_low = i; seen = 1'b1;
                end
                @(negedge clk);
            end
            chk(pl ? "R5 active count inverted" : "R4 active count", hi, hi_exp);
            chk("R3 first inactive sample", first_low, fl_exp);
        end

        // R6 double buffering: width change mid-period waits for next period
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'd7);
        wr(2'd2, 16'd4);
        wr(2'd0, 16'h0080);
        begin
            int h0, h1;
            h0 = 0; h1 = 0;
            for (int i = 0; i < 16; i++) begin
                if (pwm_out) begin
                    if (i < 8) h0++; else h1++;
                end
                if (i == 1) begin
                    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 16'd1;
                end
                if (i == 2) begin
                    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0;
                end
                @(negedge clk);
            end
            chk("R6 old width in current period", h0, 4);
            chk("R6 new width next period", h1, 1);
            chk("R7 flag sticky over periods", bus_rdata[15], 1);
        end

        // R8 / R10 handshake with a long period
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'd200);
        wr(2'd2, 16'd50);
        wr(2'd0, 16'h5080);
        chk("R10 irq_req with flag", irq_req, 1);
        chk("R10 irq_lvl", irq_lvl, 5);
        wr(2'd0, 16'h5080);
        chk("R8 zero write without read keeps flag", bus_rdata[15], 1);
        rd(2'd0, d);
        chk("R8 read sees flag", d[15], 1);
        wr(2'd0, 16'hD080);
        chk("R8 write one keeps flag", bus_rdata[15], 1);
        rd(2'd0, d);
        wr(2'd0, 16'h5080);
        chk("R8 read then zero clears flag", bus_rdata[15], 0);
        chk("R10 no request when clear", irq_req, 0);
        chk("R10 irq_lvl idle", irq_lvl, 0);
        repeat (150) @(negedge clk);
        chk("R7 flag stays clear mid-period", bus_rdata[15], 0);
        repeat (60) @(negedge clk);
        chk("R7 flag set at period end", bus_rdata[15], 1);
        wr(2'd0, 16'h0080);
        chk("R10 level zero no request", irq_req, 0);

        // R11 pin readback and load restart
        chk("R11 pin bit", bus_rdata[10], pwm_out);
        wr(2'd1, 16'd3);
        wr(2'd2, 16'd2);
        wr(2'd0, 16'h0280);
        chk("R11 load reads zero", bus_rdata[9], 0);
        begin
            int h;
            h = 0;
            for (int i = 0; i < 8; i++) begin
                if (pwm_out) h++;
                @(negedge clk);
            end
            chk("R11 load restarts with new values", h, 4);
        end

        // R9 / R5 disable
        wr(2'd0, 16'h0000);
        chk("R9 flag cleared on disable", bus_rdata[15], 0);
        chk("R9 output inactive", pwm_out, 0);
        wr(2'd0, 16'h0100);
        chk("R5 disabled output equals polarity", pwm_out, 1);

        // R12 field layout
        wr(2'd0, 16'h3907);
        chk("R12 ctrl readback", bus_rdata, 16'h3D07);
        bus_addr = 2'd1; #1 chk("R12 period readback", bus_rdata, 3);
        bus_addr = 2'd2; #1 chk("R12 width readback", bus_rdata, 2);
        bus_addr = 2'd0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule